// File: doc/BRIEF.md
# Write-Back Commit Buffer

This block sits between a functional unit's result port and the write arbitration of a vector register file. It holds one write-back bundle (instruction tag, destination row, data word and byte-lane mask) and offers it downstream as a write request until the arbiter grants that write.

The unit gets two separate acknowledgements. A capture grant pulses when its bundle is accepted into the slot, which frees the unit to produce its next result. A commit grant, tagged with the instruction the data belongs to, pulses only in the cycle the register-file write is actually granted. Dependency tracking can therefore release a hazard on the commit grant alone and never before the data is in the register file. The slot accepts a new bundle in the same cycle the old one drains, so a steady stream moves at one result per cycle.

Top module: `wb_stream_buffer`

## Requirements
- R1: After reset the slot is empty: `wr_req_o`, `cap_gnt_o` and `fin_gnt_o` are 0, the write fields read 0 and `in_ready_o` is 1.
- R2: `wr_req_o` is 1 exactly while the slot holds a bundle. The write fields show the tag, row, data and mask that were captured.
- R3: `in_ready_o` is 1 when the slot is empty, or when it is full and `wr_gnt_i` is 1 in that cycle. Otherwise it is 0.
- R4: `cap_gnt_o` is a one-cycle pulse in each cycle where `in_valid_i` and `in_ready_o` are both 1. It is 0 in all other cycles.
- R5: `fin_gnt_o` is 1 only in a cycle where `wr_req_o` and `wr_gnt_i` are both 1. In that cycle `fin_id_o` equals the tag of the bundle being written.
- R6: A `wr_gnt_i` that arrives while the slot is empty causes no commit grant and leaves the slot empty.
- R7: When a bundle drains and a new one is offered in the same cycle, the new bundle is captured. It is shown on the write fields in the next cycle, and nothing is lost.
- R8: While the slot is full and not granted, an offered bundle is not taken and the held bundle stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Unit offers a result bundle |
| in_id_i | input | ID_W | Instruction tag of the offered result |
| in_addr_i | input | ADDR_W | Destination row |
| in_data_i | input | DATA_W | Result word |
| in_be_i | input | DATA_W/8 | Byte-lane write mask |
| in_ready_o | output | 1 | Slot can take a bundle this cycle |
| cap_gnt_o | output | 1 | Capture acknowledgement pulse |
| fin_gnt_o | output | 1 | Commit acknowledgement pulse |
| fin_id_o | output | ID_W | Tag of the committed instruction |
| wr_req_o | output | 1 | Write request to the register-file arbiter |
| wr_id_o | output | ID_W | Tag of the held bundle |
| wr_addr_o | output | ADDR_W | Row of the held bundle |
| wr_data_o | output | DATA_W | Word of the held bundle |
| wr_be_o | output | DATA_W/8 | Mask of the held bundle |
| wr_gnt_i | input | 1 | Arbiter grants the write this cycle |

## Verification
The hardest case to reach is the cycle where one bundle drains and the next is captured at once. The commit grant must then carry the old tag while the capture grant acknowledges the new one. The stimulus fills the slot first, then raises the arbiter grant and a fresh offer on the same falling edge. It checks both pulses and the old tag before the edge, and the new bundle after it. A second hard case is an offer held against a full slot that gets no grant. The bench keeps that offer up for a cycle with a different bundle and then checks that the held fields are unchanged.

// File: rtl/wbsb_pkg.sv
package wbsb_pkg;
  // Packed bundle order, MSB first: id | addr | data | byte-enable
  function automatic int bundle_w(int id_w, int addr_w, int data_w);
    return id_w + addr_w + data_w + data_w / 8;
  endfunction
endpackage

// File: rtl/wbsb_ack.sv
module wbsb_ack (
  input  logic in_valid_i,
  input  logic full_i,
  input  logic wr_gnt_i,
  output logic load_o,
  output logic drain_o,
  output logic in_ready_o,
  output logic cap_gnt_o,
  output logic fin_gnt_o
);
  always_comb begin
    drain_o    = full_i & wr_gnt_i;
    in_ready_o = ~full_i | drain_o;
    load_o     = in_valid_i & in_ready_o;
    cap_gnt_o  = load_o;
    fin_gnt_o  = drain_o;
  end
endmodule

// File: rtl/wbsb_slot.sv
module wbsb_slot #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         drain_i,
  input  logic [W-1:0] din_i,
  output logic         full_o,
  output logic [W-1:0] dout_o
);
  logic         full_q, full_d;
  logic [W-1:0] data_q, data_d;
  logic         data_en;

  always_comb begin
    full_d  = full_q;
    data_en = load_i;
    data_d  = din_i;
    if (drain_i) full_d = 1'b0;
    if (load_i)  full_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
    end else begin
      full_q <= full_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_d;
    end
  end

  assign full_o = full_q;
  assign dout_o = data_q;
endmodule

// File: rtl/wb_stream_buffer.sv
module wb_stream_buffer #(
  parameter int ID_W   = 3,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  input  logic [ID_W-1:0]     in_id_i,
  input  logic [ADDR_W-1:0]   in_addr_i,
  input  logic [DATA_W-1:0]   in_data_i,
  input  logic [DATA_W/8-1:0] in_be_i,
  output logic                in_ready_o,
  output logic                cap_gnt_o,
  output logic                fin_gnt_o,
  output logic [ID_W-1:0]     fin_id_o,
  output logic                wr_req_o,
  output logic [ID_W-1:0]     wr_id_o,
  output logic [ADDR_W-1:0]   wr_addr_o,
  output logic [DATA_W-1:0]   wr_data_o,
  output logic [DATA_W/8-1:0] wr_be_o,
  input  logic                wr_gnt_i
);
  localparam int BE_W = DATA_W / 8;
  localparam int BW   = wbsb_pkg::bundle_w(ID_W, ADDR_W, DATA_W);

  logic          full, load, drain;
  logic [BW-1:0] slot_in, slot_out;

  assign slot_in = {in_id_i, in_addr_i, in_data_i, in_be_i};

  wbsb_ack u_ack (
    .in_valid_i (in_valid_i),
    .full_i     (full),
    .wr_gnt_i   (wr_gnt_i),
    .load_o     (load),
    .drain_o    (drain),
    .in_ready_o (in_ready_o),
    .cap_gnt_o  (cap_gnt_o),
    .fin_gnt_o  (fin_gnt_o)
  );

  wbsb_slot #(.W(BW)) u_slot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .drain_i (drain),
    .din_i   (slot_in),
    .full_o  (full),
    .dout_o  (slot_out)
  );

  assign wr_req_o  = full;
  assign wr_id_o   = slot_out[BW-1 -: ID_W];
  assign wr_addr_o = slot_out[BW-ID_W-1 -: ADDR_W];
  assign wr_data_o = slot_out[BE_W +: DATA_W];
  assign wr_be_o   = slot_out[0 +: BE_W];
  assign fin_id_o  = wr_id_o;
endmodule

// File: rtl/wbsb_chk.sv
module wbsb_chk #(
  parameter int ID_W   = 3,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                in_valid_i,
  input logic [ID_W-1:0]     in_id_i,
  input logic                in_ready_o,
  input logic                cap_gnt_o,
  input logic                fin_gnt_o,
  input logic [ID_W-1:0]     fin_id_o,
  input logic                wr_req_o,
  input logic [ID_W-1:0]     wr_id_o,
  input logic [DATA_W-1:0]   wr_data_o,
  input logic                wr_gnt_i
);
  // R3
  empty_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_req_o |-> in_ready_o);
  // R4
  cap_handshake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_gnt_o |-> (in_valid_i && in_ready_o));
  // R5
  fin_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_gnt_o |-> (wr_gnt_i && fin_id_o == wr_id_o));
  // R6
  no_idle_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_req_o |-> !fin_gnt_o);
  // R7
  capture_shows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_gnt_o |=> (wr_req_o && wr_id_o == $past(in_id_i)));
  // R8
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && !wr_gnt_i) |=> (wr_req_o && $stable(wr_data_o) && $stable(wr_id_o)));
endmodule

bind wb_stream_buffer wbsb_chk #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_id_i    (in_id_i),
  .in_ready_o (in_ready_o),
  .cap_gnt_o  (cap_gnt_o),
  .fin_gnt_o  (fin_gnt_o),
  .fin_id_o   (fin_id_o),
  .wr_req_o   (wr_req_o),
  .wr_id_o    (wr_id_o),
  .wr_data_o  (wr_data_o),
  .wr_gnt_i   (wr_gnt_i)
);

// File: tb/test_wb_stream_buffer.sv
module test_wb_stream_buffer;
  localparam int ID_W = 3, ADDR_W = 8, DATA_W = 32, BE_W = DATA_W / 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, wr_gnt = 1'b0;
  logic [ID_W-1:0]   in_id = '0;
  logic [ADDR_W-1:0] in_addr = '0;
  logic [DATA_W-1:0] in_data = '0;
  logic [BE_W-1:0]   in_be = '0;
  logic in_ready, cap_gnt, fin_gnt, wr_req;
  logic [ID_W-1:0] fin_id, wr_id;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [BE_W-1:0] wr_be;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  wb_stream_buffer #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_wb_stream_buffer (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_id_i(in_id),
    .in_addr_i(in_addr), .in_data_i(in_data), .in_be_i(in_be),
    .in_ready_o(in_ready), .cap_gnt_o(cap_gnt), .fin_gnt_o(fin_gnt), .fin_id_o(fin_id),
    .wr_req_o(wr_req), .wr_id_o(wr_id), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .wr_be_o(wr_be), .wr_gnt_i(wr_gnt)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic offer(input logic v, input int id, input int a, input int d, input int be);
    in_valid = v; in_id = ID_W'(id); in_addr = ADDR_W'(a); in_data = DATA_W'(d); in_be = BE_W'(be);
  endtask

  // drive at falling edge, settle, then caller checks before the rising edge
  task automatic step_drive();
    @(negedge clk); #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; offer(0, 0, 0, 0, 0); wr_gnt = 0;
    step_drive(); step_drive();
    chk("R1 wr_req", wr_req, 0);
    chk("R1 in_ready", in_ready, 1);
    chk("R1 cap_gnt", cap_gnt, 0);
    chk("R1 fin_gnt", fin_gnt, 0);
    chk("R1 wr_data", wr_data, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_single();
    @(negedge clk); offer(1, 3, 8'h15, 32'hA5A5_1234, 4'hC); wr_gnt = 0; #1;
    chk("R4 cap pulse", cap_gnt, 1);
    chk("R3 empty ready", in_ready, 1);
    @(negedge clk); offer(0, 0, 0, 0, 0); #1;
    chk("R4 no cap when idle", cap_gnt, 0);
    chk("R2 req", wr_req, 1);
    chk("R2 id", wr_id, 3);
    chk("R2 addr", wr_addr, 8'h15);
    chk("R2 data", wr_data, 32'hA5A5_1234);
    chk("R2 be", wr_be, 4'hC);
    chk("R3 full not ready", in_ready, 0);
    chk("R5 no fin without gnt", fin_gnt, 0);
    // R8: offer against a full, ungranted slot
    @(negedge clk); offer(1, 6, 8'h99, 32'h0BAD_0BAD, 4'h1); #1;
    chk("R8 no cap while full", cap_gnt, 0);
    @(negedge clk); offer(0, 0, 0, 0, 0); #1;
    chk("R8 data kept", wr_data, 32'hA5A5_1234);
    chk("R8 id kept", wr_id, 3);
    wr_gnt = 1; #1;
    chk("R5 fin pulse", fin_gnt, 1);
    chk("R5 fin id", fin_id, 3);
    chk("R3 drain ready", in_ready, 1);
    @(negedge clk); wr_gnt = 0; #1;
    chk("R2 empty after write", wr_req, 0);
    chk("R5 fin low", fin_gnt, 0);
  endtask

  task automatic t_idle_gnt();
    @(negedge clk); offer(0, 0, 0, 0, 0); wr_gnt = 1; #1;
    chk("R6 no fin when empty", fin_gnt, 0);
    @(negedge clk); wr_gnt = 0; #1;
    chk("R6 still empty", wr_req, 0);
    chk("R6 fin still low", fin_gnt, 0);
  endtask

  task automatic t_stream();
    @(negedge clk); offer(1, 1, 8'h01, 32'h1111_1111, 4'hF); #1;
    @(negedge clk); offer(1, 2, 8'h02, 32'h2222_2222, 4'h3); wr_gnt = 1; #1;
    chk("R7 fin old", fin_gnt, 1);
    chk("R7 fin id old", fin_id, 1);
    chk("R7 cap new", cap_gnt, 1);
    @(negedge clk); offer(0, 0, 0, 0, 0); wr_gnt = 0; #1;
    chk("R7 req", wr_req, 1);
    chk("R7 id new", wr_id, 2);
    chk("R7 data new", wr_data, 32'h2222_2222);
    chk("R7 be new", wr_be, 4'h3);
    @(negedge clk); wr_gnt = 1; #1;
    chk("R7 fin second", fin_id, 2);
    @(negedge clk); wr_gnt = 0; #1;
    chk("R7 drained", wr_req, 0);
  endtask

  task automatic t_reset_mid();
    @(negedge clk); offer(1, 5, 8'h55, 32'h5555_5555, 4'h5); #1;
    @(negedge clk); offer(0, 0, 0, 0, 0); #1;
    chk("R2 loaded before reset", wr_req, 1);
    rst_n = 1'b0; #1;
    chk("R1 reset empties", wr_req, 0);
    chk("R1 reset ready", in_ready, 1);
    chk("R1 reset clears id", wr_id, 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    t_reset();
    t_single();
    t_idle_gnt();
    t_stream();
    t_reset_mid();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule